// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, for every incoming frame, whether the frame is kept or dropped, based only on its 48-bit destination address. Bytes arrive one per `rx_valid` strobe, and `rx_sof` marks the first byte of a frame. The first six bytes are collected as the destination address. While they are collected, a CRC-32 runs over them byte by byte.

Once the sixth byte is in, the address is weighed against the programmed configuration:
- an exact station address for unicast traffic;
- a 64-bin hash table for group (multicast) traffic;
- three mode bits: promiscuous, pass-all-group and hash lookup.

The outcome is a one-cycle decision pulse with an accept flag and a group-frame flag. Frame storage, DMA and FCS checking are handled elsewhere.

Top module: `rx_addr_filter`

## Requirements
- R1: While and right after reset, `dec_valid`, `dec_accept` and `dec_mcast` are 0.
- R2: `dec_valid` pulses high for exactly one cycle, in the second cycle after the clock edge that samples the sixth address byte. Address byte 0 is the byte taken with `rx_sof`=1, and bytes 1..5 are the next five bytes taken with `rx_valid`=1. Cycles with `rx_valid`=0 are skipped.
- R3: The station address maps byte 0 = `sta_lo[7:0]`, byte 1 = `sta_lo[15:8]`, byte 2 = `sta_lo[23:16]`, byte 3 = `sta_lo[31:24]`, byte 4 = `sta_hi[7:0]`, byte 5 = `sta_hi[15:8]`. A unicast destination equal to it is accepted.
- R4: A unicast destination (bit 0 of byte 0 clear) that differs from the station address is dropped unless promiscuous mode is set.
- R5: With `mode_promisc`=1, every frame is accepted.
- R6: The all-ones broadcast destination is always accepted and flagged as group.
- R7: A destination is group when bit 0 of byte 0 is 1. With `mode_all_grp`=1, every group destination is accepted.
- R8: With `mode_hash`=1, a group destination is accepted if and only if table bit `idx` is set. Index values 0..31 select `hash_lo[idx]` and 32..63 select `hash_hi[idx-32]`. `idx` is bits 31:26 of a CRC-32 register computed as follows:
  - start value all ones;
  - shifted left with polynomial 0x04C11DB7;
  - fed each address byte LSB first, byte 0 first;
  - no final inversion.
- R9: A group destination other than broadcast is dropped when promiscuous, pass-all-group and hash modes are all clear.
- R10: `dec_mcast` is 1 only together with `dec_accept`=1 for a group destination. For dropped frames and accepted unicast frames it is 0.
- R11: Bytes after the sixth and before the next `rx_sof` produce no decision. A new `rx_sof` in the middle of an address restarts collection from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | First byte of frame marker |
| rx_byte | input | 8 | Received byte |
| sta_hi | input | 16 | Station address bytes 5 (upper) and 4 (lower) |
| sta_lo | input | 32 | Station address bytes 3..0, byte 3 uppermost |
| hash_hi | input | 32 | Hash table bins 32..63 |
| hash_lo | input | 32 | Hash table bins 0..31 |
| mode_promisc | input | 1 | Accept every frame |
| mode_all_grp | input | 1 | Accept every group destination |
| mode_hash | input | 1 | Hash lookup for group destinations |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_mcast | output | 1 | Accepted frame has a group destination |

## Verification
The bench builds the block with the default `HASH_BITS` of 6, so the table has its full 64 bins and the index is the full six-bit CRC slice. This makes the hash table small enough to cover exhaustively. For each of the 64 bins, the bench searches for a group address whose reference CRC lands in that bin. It then checks that a one-hot table at that bin accepts the address and that the inverted table drops it. Every combination of the three mode bits is also run against five address classes (station, foreign unicast, hashed-in group, hashed-out group, broadcast), together with stray bytes, gaps and restarts.

// File: rtl/rx_filt_pkg.sv
// Shared constants and the CRC byte step for the receive address filter.
// Assumes 8-bit bytes and a 6-byte destination address.
package rx_filt_pkg;
    localparam int          ADDR_BYTES = 6;
    localparam int          ADDR_W     = ADDR_BYTES * 8;
    localparam logic [31:0] CRC_POLY   = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT   = 32'hFFFF_FFFF;

    // Advance a left-shifting CRC-32 by one byte, taking the byte LSB first.
    function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        return c;
    endfunction
endpackage

// File: rtl/rx_filt_capture.sv
// Collects the destination address bytes of a frame and runs the CRC
// alongside. Raises addr_done for one cycle after the last address byte.
// Assumes rx_sof only accompanies rx_valid.
module rx_filt_capture
    import rx_filt_pkg::*;
#(
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic                 rx_sof,
    input  logic [7:0]           rx_byte,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [HASH_BITS-1:0] hash_idx_o,
    output logic                 addr_done_o
);
    localparam int                CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0]  IDLE  = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(ADDR_BYTES - 1);

    logic [CNT_W-1:0]      cnt_q;
    logic [31:0]           crc_q;
    logic                  done_q;
    logic [ADDR_BYTES-1:0] lane_we;

    // Select the byte lane that the current byte belongs to.
    always_comb begin
        lane_we = '0;
        if (rx_valid) begin
            if (rx_sof)
                lane_we[0] = 1'b1;
            else if (cnt_q < IDLE)
                lane_we[cnt_q] = 1'b1;
        end
    end

    // One register per address byte lane.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        logic [7:0] lane_q;
        // Hold the byte written into this lane.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= '0;
            else if (lane_we[g])
                lane_q <= rx_byte;
        end
        assign addr_o[g*8 +: 8] = lane_q;
    end

    // Byte position, running CRC and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= IDLE;
            crc_q  <= CRC_INIT;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (rx_valid) begin
                if (rx_sof) begin
                    cnt_q <= CNT_W'(1);
                    crc_q <= crc_step(CRC_INIT, rx_byte);
                end else if (cnt_q < IDLE) begin
                    cnt_q  <= cnt_q + CNT_W'(1);
                    crc_q  <= crc_step(crc_q, rx_byte);
                    done_q <= (cnt_q == LAST);
                end
            end
        end
    end

    assign hash_idx_o  = crc_q[31 -: HASH_BITS];
    assign addr_done_o = done_q;

    p_cnt_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= IDLE);
    p_done_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(rx_valid) && !$past(rx_sof)));
endmodule

// File: rtl/rx_filt_hash.sv
// Looks up one bin of the group hash table, split over two halves.
// Assumes HASH_BITS >= 1.
module rx_filt_hash #(
    parameter int HASH_BITS = 6,
    localparam int HALF = 1 << (HASH_BITS - 1)
) (
    input  logic [HASH_BITS-1:0] idx_i,
    input  logic [HALF-1:0]      tbl_hi_i,
    input  logic [HALF-1:0]      tbl_lo_i,
    output logic                 hit_o
);
    logic [2*HALF-1:0] table_w;

    // Join the halves, low half holding the lower bins, and pick the bin.
    always_comb begin
        table_w = {tbl_hi_i, tbl_lo_i};
        hit_o   = table_w[idx_i];
    end
endmodule

// File: rtl/rx_filt_decide.sv
// Combines address class, station match, hash hit and mode bits into a
// registered accept decision. Assumes the inputs are stable while addr_done_i is high.
module rx_filt_decide
    import rx_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_done_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] station_i,
    input  logic              hash_hit_i,
    input  logic              promisc_i,
    input  logic              all_grp_i,
    input  logic              hash_en_i,
    output logic              dec_valid_o,
    output logic              dec_accept_o,
    output logic              dec_mcast_o
);
    logic grp, bcast, match, acc_c;

    // Classify the destination and form the accept term.
    always_comb begin
        grp   = addr_i[0];
        bcast = &addr_i;
        match = (addr_i == station_i);
        acc_c = promisc_i | bcast | (!grp & match) |
                (grp & all_grp_i) | (grp & hash_en_i & hash_hit_i);
    end

    // Register the decision pulse and its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid_o  <= 1'b0;
            dec_accept_o <= 1'b0;
            dec_mcast_o  <= 1'b0;
        end else begin
            dec_valid_o  <= addr_done_i;
            dec_accept_o <= addr_done_i & acc_c;
            dec_mcast_o  <= addr_done_i & acc_c & grp;
        end
    end

    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |=> !dec_valid_o);
    p_promisc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && $past(promisc_i)) |-> dec_accept_o);
    p_bcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && $past(&addr_i)) |-> (dec_accept_o && dec_mcast_o));
endmodule

// File: rtl/rx_addr_filter.sv
// Receive destination address filter: captures the first six bytes of a
// frame and reports accept/group flags two cycles after the sixth byte.
// Assumes configuration is held steady around the decision point.
module rx_addr_filter
    import rx_filt_pkg::*;
#(
    parameter int HASH_BITS = 6,
    localparam int HALF = 1 << (HASH_BITS - 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_valid,
    input  logic            rx_sof,
    input  logic [7:0]      rx_byte,
    input  logic [15:0]     sta_hi,
    input  logic [31:0]     sta_lo,
    input  logic [HALF-1:0] hash_hi,
    input  logic [HALF-1:0] hash_lo,
    input  logic            mode_promisc,
    input  logic            mode_all_grp,
    input  logic            mode_hash,
    output logic            dec_valid,
    output logic            dec_accept,
    output logic            dec_mcast
);
    logic [ADDR_W-1:0]    addr_w;
    logic [HASH_BITS-1:0] idx_w;
    logic                 done_w;
    logic                 hit_w;

    rx_filt_capture #(.HASH_BITS(HASH_BITS)) u_cap (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_byte(rx_byte), .addr_o(addr_w), .hash_idx_o(idx_w),
        .addr_done_o(done_w)
    );

    rx_filt_hash #(.HASH_BITS(HASH_BITS)) u_hash (
        .idx_i(idx_w), .tbl_hi_i(hash_hi), .tbl_lo_i(hash_lo), .hit_o(hit_w)
    );

    rx_filt_decide u_dec (
        .clk(clk), .rst_n(rst_n), .addr_done_i(done_w), .addr_i(addr_w),
        .station_i({sta_hi, sta_lo}), .hash_hit_i(hit_w),
        .promisc_i(mode_promisc), .all_grp_i(mode_all_grp), .hash_en_i(mode_hash),
        .dec_valid_o(dec_valid), .dec_accept_o(dec_accept), .dec_mcast_o(dec_mcast)
    );
endmodule

// File: tb/rx_addr_filter_tb_top.sv
`timescale 1ns/1ps
module rx_addr_filter_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0, rx_sof = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [15:0] sta_hi;
    logic [31:0] sta_lo;
    logic [31:0] hash_hi = '0, hash_lo = '0;
    logic mode_promisc = 1'b0, mode_all_grp = 1'b0, mode_hash = 1'b0;
    logic dec_valid, dec_accept, dec_mcast;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    localparam logic [47:0] STA = 48'hA1B2_03C4_D5E6;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    always #2.5 clk = ~clk;

    rx_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_byte(rx_byte), .sta_hi(sta_hi), .sta_lo(sta_lo),
        .hash_hi(hash_hi), .hash_lo(hash_lo), .mode_promisc(mode_promisc),
        .mode_all_grp(mode_all_grp), .mode_hash(mode_hash),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_mcast(dec_mcast)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference index via the reflected CRC, bit-reversed into normal order.
    function automatic int ref_idx(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++)
            c = (c[0] ^ a[k]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        return int'({c[0], c[1], c[2], c[3], c[4], c[5]});
    endfunction

    function automatic logic ref_accept(input logic [47:0] a, input logic [63:0] t,
                                        input logic p, input logic ag, input logic h);
        logic g;
        g = a[0];
        return p | (a == BCAST) | (!g & (a == STA)) | (g & ag) | (g & h & t[ref_idx(a)]);
    endfunction

    function automatic logic [47:0] cand(input int k);
        return {16'(k * 40503 + 7), 16'(k * 9 + 1), 8'h3C, 8'((k & 8'hFE) | 1)};
    endfunction

    task automatic set_tbl(input logic [63:0] t);
        hash_lo = t[31:0];
        hash_hi = t[63:32];
    endtask

    // Drive one address (optionally with a gap and trailing bytes) and
    // collect the decision at its expected cycle.
    task automatic send(input logic [47:0] a, input bit gap, input int extra,
                        output logic acc, output logic mc);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (gap && i == 3) begin
                rx_valid = 1'b0; rx_sof = 1'b0; rx_byte = 8'hFF;
                @(negedge clk);
            end
            rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = a[8*i +: 8];
        end
        @(negedge clk);
        rx_sof = 1'b0; rx_valid = (extra > 0); rx_byte = 8'h55;
        chk("R2 no early decision", 64'(dec_valid), 64'd0);
        @(negedge clk);
        chk("R2 decision cycle", 64'(dec_valid), 64'd1);
        acc = dec_accept; mc = dec_mcast;
        for (int e = 1; e < extra; e++) begin
            rx_byte = 8'(e);
            @(negedge clk);
            chk("R11 trailing bytes ignored", 64'(dec_valid), 64'd0);
        end
        rx_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic acc, mc;
        logic [47:0] cls [5];
        logic [47:0] m1, m2;
        logic [63:0] t;
        int found;
        sta_hi = STA[47:32];
        sta_lo = STA[31:0];
        repeat (4) @(negedge clk);
        chk("R1 reset valid", 64'(dec_valid), 64'd0);
        chk("R1 reset accept", 64'(dec_accept), 64'd0);
        chk("R1 reset mcast", 64'(dec_mcast), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 64'({dec_valid, dec_accept, dec_mcast}), 64'd0);

        // R3 station match, with gap and trailing bytes
        send(STA, 1'b0, 0, acc, mc);
        chk("R3 station accept", 64'(acc), 64'd1);
        chk("R10 unicast no mcast", 64'(mc), 64'd0);
        send(STA, 1'b1, 8, acc, mc);
        chk("R3 station with gap", 64'(acc), 64'd1);
        // R4 each byte mismatch
        for (int b = 0; b < 6; b++) begin
            send(STA ^ (48'h2 << (8 * b)), 1'b0, 0, acc, mc);
            chk("R4 mismatch dropped", 64'(acc), 64'd0);
            chk("R10 dropped no mcast", 64'(mc), 64'd0);
        end

        // R11 restart mid-address
        @(negedge clk);
        rx_valid = 1'b1; rx_sof = 1'b1; rx_byte = 8'h11;
        @(negedge clk);
        rx_sof = 1'b0; rx_byte = 8'h22;
        @(negedge clk);
        rx_byte = 8'h33;
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R11 partial no decision", 64'(dec_valid), 64'd0);
        send(STA, 1'b0, 0, acc, mc);
        chk("R11 restart accepted", 64'(acc), 64'd1);

        // Mode sweep over address classes
        m1 = cand(0);
        found = 0;
        m2 = m1;
        for (int k = 1; k < 100 && found == 0; k++) begin
            if (ref_idx(cand(k)) != ref_idx(m1)) begin m2 = cand(k); found = 1; end
        end
        t = 64'd1 << ref_idx(m1);
        set_tbl(t);
        cls[0] = STA; cls[1] = STA ^ 48'h0100_0000_0000; cls[2] = m1; cls[3] = m2; cls[4] = BCAST;
        for (int md = 0; md < 8; md++) begin
            mode_promisc = md[0]; mode_all_grp = md[1]; mode_hash = md[2];
            for (int c = 0; c < 5; c++) begin
                logic e;
                e = ref_accept(cls[c], t, md[0], md[1], md[2]);
                send(cls[c], 1'b0, 0, acc, mc);
                chk("R5/R6/R7/R9 mode sweep accept", 64'(acc), 64'(e));
                chk("R10 mode sweep mcast", 64'(mc), 64'(e & cls[c][0]));
            end
        end
        mode_promisc = 1'b0; mode_all_grp = 1'b0; mode_hash = 1'b0;
        send(m1, 1'b0, 0, acc, mc);
        chk("R9 group dropped no modes", 64'(acc), 64'd0);
        send(BCAST, 1'b0, 0, acc, mc);
        chk("R6 broadcast accept", 64'(acc), 64'd1);
        chk("R6 broadcast group flag", 64'(mc), 64'd1);

        // R8 every hash bin
        mode_hash = 1'b1;
        for (int b = 0; b < 64; b++) begin
            logic [47:0] a;
            a = '0;
            found = 0;
            for (int k = 0; k < 6000 && found == 0; k++) begin
                if (ref_idx(cand(k)) == b) begin a = cand(k); found = 1; end
            end
            chk("R8 bin address found", 64'(found), 64'd1);
            set_tbl(64'd1 << b);
            send(a, 1'b0, 0, acc, mc);
            chk("R8 bin hit accept", 64'(acc), 64'd1);
            chk("R8 bin hit mcast", 64'(mc), 64'd1);
            set_tbl(~(64'd1 << b));
            send(a, 1'b0, 0, acc, mc);
            chk("R8 bin miss drop", 64'(acc), 64'd0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule